// File: doc/BRIEF.md
# Three-Axis Bresenham Step Generator with Adaptive Smoothing

This block turns a stream of constant-rate motion segments into step and direction pulses for three axes. Software first loads block records through a simple write port. A record holds a direction bit per axis, a 32-bit step count per axis and a 32-bit step-event count. Each segment then names one record, a number of steps, a timer period and a smoothing level. The block accepts segments over a valid/ready handshake and runs one segment at a time.

A tick timer divides the clock. At level n the segment's period is shifted right by n, so ticks come 2^n times faster. The event count used by the line tracer is shifted left by n, while the per-axis counts stay the same. As a result, the dominant axis still steps once every 2^n ticks, and the other axes can step on the ticks in between. This spreads the steps of slow multi-axis moves more evenly. The intended choice of level is 0 above 8 kHz, 1 below 8 kHz, 2 below 4 kHz and 3 below 2 kHz. The multiplied tick rate should stay at or below the 16 kHz target. Choosing the level is the job of whatever prepares the segments.

Top module: `bres_step3`

## Requirements
- R1: The record store has SEG_DEPTH-1 entries, written by `rec_we` at `rec_idx`. A segment uses the record whose index it carries, including that record's direction bits.
- R2: `dir_o` takes the direction bits of the record when a segment is accepted. It changes at no other time, so it is valid at least one clock before that segment's first step pulse. It keeps its value while idle.
- R3: The effective tick period is `seg_period >> seg_level` clocks, with a minimum of 1. A segment lasts `seg_nstep << seg_level` ticks. From acceptance to `idle_o` rising therefore takes ticks × effective period clocks.
- R4: A segment with `seg_new`=1 sets each axis counter to E/2 (rounded down), where E = events << level. On each tick the axis count S is added to the counter. If the sum exceeds E, that axis steps and E is subtracted. After T ticks, an axis has stepped floor((E/2 + T·S − 1)/E) times.
- R5: An axis whose step count equals the record's event count steps exactly once every 2^level ticks.
- R6: Each step pulse stays high for `pulse_width` clocks (a value of 0 acts as 1), then returns low. `pulse_width` must be below the effective tick period.
- R7: `seg_ready` is high on a segment's last tick, so a waiting segment loads with no idle tick in between. A segment with `seg_new`=0 continues the running counters.
- R8: With no segment running, `idle_o` and `seg_ready` are high, and no new step pulse starts.
- R9: After reset, `step_o` and `dir_o` are 0, `idle_o` is 1 and `seg_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rec_we | input | 1 | Record write strobe |
| rec_idx | input | IW | Record index to write |
| rec_dir | input | AXES | Direction bits of the record |
| rec_steps | input | AXES*32 | Step counts per axis, axis 0 in the low 32 bits |
| rec_events | input | 32 | Step-event count of the record |
| seg_valid | input | 1 | A segment is offered |
| seg_ready | output | 1 | The block accepts the offered segment this clock |
| seg_nstep | input | 16 | Steps in the segment |
| seg_idx | input | IW | Record used by the segment |
| seg_period | input | 16 | Clocks per tick at level 0 |
| seg_level | input | 2 | Smoothing level, 0 to 3 |
| seg_new | input | 1 | Segment starts a record, so the counters are set to E/2 |
| pulse_width | input | PW_W | Step pulse width in clocks |
| step_o | output | AXES | Step pulses |
| dir_o | output | AXES | Direction outputs |
| idle_o | output | 1 | No segment running |

## Verification
Some behaviours are checked on every cycle by assertions:
- a step pulse only rises on the clock after a tick;
- no pulse starts while idle;
- `dir_o` changes only on the clock after a segment is accepted;
- `seg_ready` is high whenever the block is idle;
- a running segment always has ticks left.

Other behaviours only show up over a whole segment, so only the bench scenarios can confirm them: the step totals per axis for each level, the spacing of dominant-axis steps, the pulse width, the busy time, and the seamless join of two segments.

// File: rtl/bres_step3.sv
module bres_step3 #(
  parameter int SEG_DEPTH = 4,
  parameter int AXES      = 3,
  parameter int PW_W      = 8,
  localparam int REC_N    = SEG_DEPTH - 1,
  localparam int IW       = (REC_N > 1) ? $clog2(REC_N) : 1,
  localparam int CW       = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_we,
  input  logic [IW-1:0]    rec_idx,
  input  logic [AXES-1:0]  rec_dir,
  input  logic [AXES*32-1:0] rec_steps,
  input  logic [31:0]      rec_events,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [15:0]      seg_nstep,
  input  logic [IW-1:0]    seg_idx,
  input  logic [15:0]      seg_period,
  input  logic [1:0]       seg_level,
  input  logic             seg_new,
  input  logic [PW_W-1:0]  pulse_width,
  output logic [AXES-1:0]  step_o,
  output logic [AXES-1:0]  dir_o,
  output logic             idle_o
);

  logic [AXES-1:0] r_dir [REC_N];
  logic [31:0]     r_st  [REC_N][AXES];
  logic [31:0]     r_ev  [REC_N];

  logic            active;
  logic [IW-1:0]   cur_idx;
  logic [1:0]      cur_lvl;
  logic [15:0]     per_q, tcnt;
  logic [18:0]     rem;
  logic [PW_W-1:0] pcnt;
  logic [CW-1:0]   cnt [AXES];
  logic [CW-1:0]   sum [AXES];
  logic [AXES-1:0] hit;
  logic [CW-1:0]   e_cur, e_new;
  logic [15:0]     per_new;
  logic            tick, last, load;

  assign e_cur   = {8'd0, r_ev[cur_idx]} << cur_lvl;
  assign e_new   = {8'd0, r_ev[seg_idx]} << seg_level;
  assign per_new = ((seg_period >> seg_level) == 16'd0) ? 16'd1 : (seg_period >> seg_level);
  assign tick    = active && (tcnt == per_q - 16'd1);
  assign last    = tick && (rem <= 19'd1);
  assign seg_ready = !active || last;
  assign load    = seg_valid && seg_ready;
  assign idle_o  = !active;

  always_ff @(posedge clk) begin
    if (rec_we && (int'(rec_idx) < REC_N)) begin
      r_dir[rec_idx] <= rec_dir;
      r_ev[rec_idx]  <= rec_events;
      for (int a = 0; a < AXES; a++) r_st[rec_idx][a] <= rec_steps[a*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cur_idx <= '0;
      cur_lvl <= '0;
      per_q   <= 16'd1;
      tcnt    <= '0;
      rem     <= '0;
      dir_o   <= '0;
    end else if (load) begin
      active  <= 1'b1;
      cur_idx <= seg_idx;
      cur_lvl <= seg_level;
      per_q   <= per_new;
      tcnt    <= '0;
      rem     <= {3'd0, seg_nstep} << seg_level;
      dir_o   <= r_dir[seg_idx];
    end else if (last) begin
      active  <= 1'b0;
      tcnt    <= '0;
      rem     <= '0;
    end else if (tick) begin
      tcnt    <= '0;
      rem     <= rem - 19'd1;
    end else if (active) begin
      tcnt    <= tcnt + 16'd1;
    end
  end

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    assign sum[a] = cnt[a] + {8'd0, r_st[cur_idx][a]};
    assign hit[a] = sum[a] > e_cur;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt[a] <= '0;
      else if (load && seg_new)  cnt[a] <= e_new >> 1;
      else if (tick)             cnt[a] <= hit[a] ? sum[a] - e_cur : sum[a];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_o <= '0;
      pcnt   <= '0;
    end else if (tick && |hit) begin
      step_o <= hit;
      pcnt   <= (pulse_width == '0) ? PW_W'(1) : pulse_width;
    end else if (pcnt > PW_W'(1)) begin
      pcnt   <= pcnt - PW_W'(1);
    end else if (pcnt == PW_W'(1)) begin
      pcnt   <= '0;
      step_o <= '0;
    end
  end

  AST_STEP_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (|(step_o & ~$past(step_o))) |-> $past(tick)); // R4
  AST_IDLE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idle_o) |-> !(|(step_o & ~$past(step_o)))); // R8
  AST_DIR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_o != $past(dir_o)) |-> $past(load)); // R2
  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> seg_ready); // R8
  AST_TICKS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (rem != 19'd0)); // R3

endmodule

// File: tb/bres_step3_tb.sv
module bres_step3_tb;
  localparam int CLK_P = 10;
  localparam int NV = 4;
  localparam int V_EV  [NV] = '{10, 6, 20, 4};
  localparam int V_SX  [NV] = '{10, 6, 20, 4};
  localparam int V_SY  [NV] = '{3, 1, 5, 3};
  localparam int V_SZ  [NV] = '{7, 4, 13, 0};
  localparam int V_NS  [NV] = '{10, 6, 7, 4};
  localparam int V_PER [NV] = '{8, 16, 10, 24};
  localparam int V_LVL [NV] = '{0, 2, 1, 3};
  localparam int V_PW  [NV] = '{2, 3, 1, 2};
  localparam int V_DIR [NV] = '{5, 2, 7, 1};
  localparam int V_IDX [NV] = '{0, 1, 2, 0};

  logic clk = 0, rst_n = 0;
  logic rec_we = 0; logic [1:0] rec_idx = 0; logic [2:0] rec_dir = 0;
  logic [95:0] rec_steps = 0; logic [31:0] rec_events = 0;
  logic seg_valid = 0, seg_new = 0; logic seg_ready;
  logic [15:0] seg_nstep = 0, seg_period = 0; logic [1:0] seg_idx = 0, seg_level = 0;
  logic [7:0] pulse_width = 1;
  logic [2:0] step_o, dir_o; logic idle_o;

  int checks = 0, fails = 0;
  int rises[3]; int busy, cyc, last_rise, gap, plen, hlen; bit seen1, gap_set;
  logic [2:0] prev;

  always #(CLK_P/2) clk = ~clk;

  bres_step3 u_dut (.clk, .rst_n, .rec_we, .rec_idx, .rec_dir, .rec_steps, .rec_events,
    .seg_valid, .seg_ready, .seg_nstep, .seg_idx, .seg_period, .seg_level, .seg_new,
    .pulse_width, .step_o, .dir_o, .idle_o);

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !idle_o) busy++;
    for (int a = 0; a < 3; a++) if (step_o[a] && !prev[a]) rises[a]++;
    if (step_o[0] && !prev[0]) begin
      if (seen1 && !gap_set) begin gap = cyc - last_rise; gap_set = 1; end
      seen1 = 1; last_rise = cyc;
    end
    if (step_o[0]) hlen++;
    else if (prev[0]) begin plen = hlen; hlen = 0; end
    prev = step_o;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic clear_meas();
    @(negedge clk);
    busy = 0; seen1 = 0; gap_set = 0; gap = 0; plen = 0; hlen = 0;
    for (int a = 0; a < 3; a++) rises[a] = 0;
  endtask

  task automatic wr_rec(input int idx, input int dir, input int ev, input int sx, input int sy, input int sz);
    @(negedge clk);
    rec_we = 1; rec_idx = idx[1:0]; rec_dir = dir[2:0]; rec_events = ev;
    rec_steps = {sz[31:0], sy[31:0], sx[31:0]};
    @(negedge clk); rec_we = 0;
  endtask

  task automatic send(input int ns, input int idx, input int per, input int lvl, input bit nw);
    @(negedge clk);
    seg_valid = 1; seg_nstep = ns[15:0]; seg_idx = idx[1:0]; seg_period = per[15:0];
    seg_level = lvl[1:0]; seg_new = nw;
    while (!seg_ready) @(negedge clk);
    @(posedge clk); #1; seg_valid = 0;
  endtask

  task automatic wait_idle(input int pw);
    @(negedge clk);
    while (!idle_o) @(negedge clk);
    repeat (pw + 2) @(negedge clk);
  endtask

  function automatic longint expect_steps(input longint ev, input longint s, input longint ns, input int lvl);
    longint e, t;
    e = ev << lvl; t = ns << lvl;
    return (e / 2 + t * s - 1) / e;
  endfunction

  initial begin
    #(CLK_P * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(step_o == 0, "R9 step", step_o, 0);
    chk(dir_o == 0, "R9 dir", dir_o, 0);
    chk(idle_o == 1, "R9 idle", idle_o, 1);
    chk(seg_ready == 1, "R9 ready", seg_ready, 1);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      int pe, s3[3];
      wr_rec(V_IDX[v], V_DIR[v], V_EV[v], V_SX[v], V_SY[v], V_SZ[v]);
      pulse_width = V_PW[v][7:0];
      clear_meas();
      send(V_NS[v], V_IDX[v], V_PER[v], V_LVL[v], 1);
      @(negedge clk);
      chk(dir_o == V_DIR[v][2:0], "R1 R2 dir from record", dir_o, V_DIR[v]);
      chk(step_o == 0, "R2 dir before step", step_o, 0);
      wait_idle(V_PW[v]);
      pe = V_PER[v] >> V_LVL[v];
      s3 = '{V_SX[v], V_SY[v], V_SZ[v]};
      for (int a = 0; a < 3; a++)
        chk(rises[a] == expect_steps(V_EV[v], s3[a], V_NS[v], V_LVL[v]), "R4 step count",
            rises[a], expect_steps(V_EV[v], s3[a], V_NS[v], V_LVL[v]));
      chk(busy == (V_NS[v] << V_LVL[v]) * pe, "R3 busy cycles", busy, (V_NS[v] << V_LVL[v]) * pe);
      chk(gap == pe << V_LVL[v], "R5 dominant spacing", gap, pe << V_LVL[v]);
      chk(plen == V_PW[v], "R6 pulse width", plen, V_PW[v]);
      chk(step_o == 0 && idle_o && seg_ready, "R8 idle state", {idle_o, seg_ready, step_o}, 6'b110000 >> 1);
      chk(dir_o == V_DIR[v][2:0], "R2 dir held idle", dir_o, V_DIR[v]);
    end

    // R7 two segments of one record joined with no idle tick
    wr_rec(1, 6, 12, 12, 5, 9);
    pulse_width = 1;
    clear_meas();
    send(5, 1, 8, 1, 1);
    send(7, 1, 8, 1, 0);
    wait_idle(1);
    chk(rises[0] == 12, "R7 joined x", rises[0], 12);
    chk(rises[1] == 5, "R7 joined y", rises[1], 5);
    chk(rises[2] == 9, "R7 joined z", rises[2], 9);
    chk(busy == 96, "R7 no idle tick", busy, 96);

    // R8 nothing starts while idle
    clear_meas();
    repeat (40) @(negedge clk);
    chk(rises[0] + rises[1] + rises[2] == 0, "R8 no step idle", rises[0] + rises[1] + rises[2], 0);

    // R3 period below 2^level clamps to one clock per tick
    wr_rec(0, 3, 2, 2, 1, 0);
    clear_meas();
    send(2, 0, 2, 2, 1);
    wait_idle(1);
    chk(busy == 8, "R3 minimum period", busy, 8);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule